// File: doc/BRIEF.md
# Flash Row Write Buffer Controller

This block collects bytes for one row of on-chip program memory and then programs that whole row in a single timed operation. A requester sends byte writes into a bank of one-byte holding registers, one register per byte of the row. The low address bits of each write select the register. These writes never touch the memory array.

A separate start request begins the long write. It names the target row, and that row is captured when the request is accepted. While the long write runs, the block raises `busy`, which the surrounding core uses as an execution stall. An internal cycle timer ends the operation. The requester has no way to end it.

Programming can only clear bits. Each memory byte becomes its old value ANDed with its holding register. The holding registers read as FFh after reset and after every long write. A byte left at FFh therefore leaves memory unchanged, and a partial row update needs only the bytes that change. The memory array is modelled as registers, with a combinational read port for inspection.

The byte-write path is valid/ready:
- A write is taken on a rising edge where `wr_valid` and `wr_ready` are both high.
- `wr_ready` is low for the whole long write, which is the only back-pressure.
- A source that holds `wr_valid` high during that time has its write taken in the first idle cycle.
- `prog_req` is a plain control pin. It is acted on only when `busy` is low and is dropped otherwise.

Top module: `flash_row_writer`

## Requirements
- R1: After reset, every memory byte reads FFh, every holding register is FFh, `busy` and `done` are 0 and `wr_ready` is 1.
- R2: A byte write taken while idle (`wr_valid` and `wr_ready` high at a rising edge) loads holding register `wr_ofs` with `wr_data`, and the memory array does not change.
- R3: A `prog_req` taken while idle raises `busy` on the next cycle, and `busy` then stays high for exactly PROG_CYCLES cycles.
- R4: While `busy` is high, `wr_ready` is 0, byte writes have no effect on the holding registers, and `prog_req` is ignored.
- R5: At the end of a long write, every byte b of the row captured from `prog_row` becomes old(b) AND hold(b). The whole row is committed at once.
- R6: A holding byte of FFh leaves its memory byte unchanged, so a partial row load is legal and no memory bit ever changes from 0 to 1.
- R7: All holding registers return to FFh when a long write completes, so an immediate second long write with no byte writes changes nothing.
- R8: `done` is high for exactly one cycle, the first cycle after `busy` falls. The committed data is visible on the read port in that cycle, and memory changes in no other cycle.
- R9: Rows other than the captured row are unchanged by a long write.
- R10: `rd_data` combinationally shows memory byte `rd_addr`, where the row number forms the upper address bits and the byte offset the lower bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte write offered |
| wr_ready | output | 1 | Byte write can be taken (low while busy) |
| wr_ofs | input | log2(ROW_BYTES) | Holding register index within the row |
| wr_data | input | 8 | Byte to stage |
| prog_req | input | 1 | Start a long write |
| prog_row | input | log2(ROWS) | Row to program, captured on acceptance |
| busy | output | 1 | Long write in progress; stall the core |
| done | output | 1 | One-cycle pulse after a long write ends |
| rd_addr | input | log2(ROWS)+log2(ROW_BYTES) | Memory byte address {row, offset} |
| rd_data | output | 8 | Memory byte at rd_addr |

## Verification
The bound checker checks on every cycle the rules that are visible at the ports:
- back-pressure while busy;
- the start-to-busy step and the exact busy length;
- the one-cycle `done` pulse after busy falls;
- that a held read address returns a stable byte outside the `done` cycle;
- that no memory bit ever rises.

Only the bench scenarios can show that each byte lands at the right offset and the right captured row, that the commit is a bitwise AND, that writes and requests during busy are really dropped, and that the holding bank returns to FFh. The bench shows these by comparing every memory byte against its own model after each directed and random program sequence.

// File: rtl/frw_pkg.sv
package frw_pkg;
  typedef logic [7:0] byte_t;
  localparam byte_t ERASED = 8'hFF;
endpackage

// File: rtl/frw_hold_bank.sv
module frw_hold_bank
  import frw_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  localparam int OFS_W = $clog2(ROW_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [OFS_W-1:0]       waddr,
  input  byte_t                  wdata,
  input  logic                   clear,
  output logic [ROW_BYTES*8-1:0] row_flat
);
  // one register per row byte; an erase value of FFh means "leave alone"
  for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
    byte_t cell_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) cell_q <= ERASED;
      else if (we && waddr == OFS_W'(b)) cell_q <= wdata;
    end
    assign row_flat[b*8 +: 8] = cell_q;
  end
endmodule

// File: rtl/frw_prog_timer.sv
module frw_prog_timer #(
  parameter int PROG_CYCLES = 8,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic expire
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(PROG_CYCLES - 1);
      end
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy   = busy_q;
  assign expire = busy_q && (cnt_q == '0);
endmodule

// File: rtl/frw_mem_array.sv
module frw_mem_array
  import frw_pkg::*;
#(
  parameter int ROWS      = 4,
  parameter int ROW_BYTES = 64,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int DEPTH = ROWS * ROW_BYTES,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit,
  input  logic [ROW_W-1:0]       commit_row,
  input  logic [ROW_BYTES*8-1:0] hold_flat,
  input  logic [AW-1:0]          rd_addr,
  output byte_t                  rd_data
);
  byte_t mem_w [DEPTH];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_col
      byte_t cell_q;
      // programming only clears bits: new = old AND staged
      always_ff @(posedge clk) begin
        if (!rst_n) cell_q <= ERASED;
        else if (commit && commit_row == ROW_W'(r))
          cell_q <= cell_q & hold_flat[b*8 +: 8];
      end
      assign mem_w[r*ROW_BYTES + b] = cell_q;
    end
  end

  assign rd_data = mem_w[rd_addr];
endmodule

// File: rtl/flash_row_writer.sv
module flash_row_writer
  import frw_pkg::*;
#(
  parameter int ROWS        = 4,
  parameter int ROW_BYTES   = 64,
  parameter int PROG_CYCLES = 8,
  localparam int OFS_W = $clog2(ROW_BYTES),
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int AW    = $clog2(ROWS * ROW_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [OFS_W-1:0] wr_ofs,
  input  logic [7:0]       wr_data,
  input  logic             prog_req,
  input  logic [ROW_W-1:0] prog_row,
  output logic             busy,
  output logic             done,
  input  logic [AW-1:0]    rd_addr,
  output logic [7:0]       rd_data
);
  logic                   busy_w, expire_w, take_wr, take_go, done_q;
  logic [ROW_W-1:0]       row_q;
  logic [ROW_BYTES*8-1:0] hold_flat;

  assign take_wr = wr_valid && !busy_w;
  assign take_go = prog_req && !busy_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (take_go) row_q <= prog_row;
      done_q <= expire_w;
    end
  end

  frw_hold_bank #(.ROW_BYTES(ROW_BYTES)) hold_i (
    .clk(clk), .rst_n(rst_n), .we(take_wr), .waddr(wr_ofs),
    .wdata(wr_data), .clear(expire_w), .row_flat(hold_flat)
  );

  frw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(take_go),
    .busy(busy_w), .expire(expire_w)
  );

  frw_mem_array #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES)) mem_i (
    .clk(clk), .rst_n(rst_n), .commit(expire_w), .commit_row(row_q),
    .hold_flat(hold_flat), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assign wr_ready = !busy_w;
  assign busy     = busy_w;
  assign done     = done_q;
endmodule

// File: rtl/frw_checker.sv
module frw_checker #(
  parameter int ROWS        = 4,
  parameter int ROW_BYTES   = 64,
  parameter int PROG_CYCLES = 8,
  localparam int AW = $clog2(ROWS * ROW_BYTES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic          prog_req,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] rd_addr,
  input logic [7:0]    rd_data
);
  int unsigned busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R4
  stall_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_valid) |-> !wr_ready);
  // R3
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !busy) |=> busy);
  // R3
  busy_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < PROG_CYCLES));
  // R3
  busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == PROG_CYCLES));
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  mem_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $stable(rd_addr)) |-> $stable(rd_data));
  // R6
  no_bit_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rd_addr) |-> ((rd_data & ~$past(rd_data)) == 8'h00));
endmodule

bind flash_row_writer frw_checker #(
  .ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)
) chk_i (.*);

// File: tb/flash_row_writer_tb.sv
`timescale 1ns/1ps
module flash_row_writer_tb_top;
  localparam int ROWS = 4, ROW_BYTES = 64, PROG_CYCLES = 8;
  localparam int OFS_W = $clog2(ROW_BYTES), ROW_W = $clog2(ROWS);
  localparam int AW = OFS_W + ROW_W, DEPTH = ROWS * ROW_BYTES;

  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, wr_ready, prog_req = 0, busy, done;
  logic [OFS_W-1:0] wr_ofs = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic [ROW_W-1:0] prog_row = '0;
  logic [AW-1:0] rd_addr = '0;

  int total = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mem_m [DEPTH];
  logic [7:0] hold_m [ROW_BYTES];

  always #5 clk = ~clk;

  flash_row_writer #(.ROWS(ROWS), .ROW_BYTES(ROW_BYTES), .PROG_CYCLES(PROG_CYCLES)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_ofs(wr_ofs), .wr_data(wr_data), .prog_req(prog_req), .prog_row(prog_row),
    .busy(busy), .done(done), .rd_addr(rd_addr), .rd_data(rd_data));

  function automatic logic [7:0] commit_byte(logic [7:0] old_v, logic [7:0] staged);
    return old_v & staged;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic verify_mem(string req);
    for (int a = 0; a < DEPTH; a++) begin
      rd_addr = AW'(a);
      #0.01;
      chk(req, rd_data, mem_m[a]);
    end
  endtask

  task automatic put_byte(int ofs, logic [7:0] d);
    @(negedge clk);
    chk("R2 ready while idle", wr_ready, 1);
    wr_valid = 1; wr_ofs = OFS_W'(ofs); wr_data = d;
    @(negedge clk);
    wr_valid = 0;
    hold_m[ofs] = d;
  endtask

  task automatic run_prog(int row, bit inject);
    int nb;
    @(negedge clk);
    prog_req = 1; prog_row = ROW_W'(row);
    @(negedge clk);
    prog_req = 0;
    chk("R3 busy after start", busy, 1);
    chk("R8 no done while busy", done, 0);
    if (inject) begin
      // R4: a clearing write and a request for another row, both to be dropped
      wr_valid = 1; wr_ofs = OFS_W'(5); wr_data = 8'h00;
      prog_req = 1; prog_row = ROW_W'(row ^ 1);
      #1 chk("R4 not ready while busy", wr_ready, 0);
    end
    nb = 1;
    forever begin
      @(negedge clk);
      wr_valid = 0; prog_req = 0;
      if (!busy) break;
      nb++;
      if (nb > PROG_CYCLES + 4) break;
    end
    chk("R3 busy length", nb, PROG_CYCLES);
    chk("R8 done after busy", done, 1);
    for (int b = 0; b < ROW_BYTES; b++) begin
      mem_m[row*ROW_BYTES + b] = commit_byte(mem_m[row*ROW_BYTES + b], hold_m[b]);
      hold_m[b] = 8'hFF;
    end
    verify_mem("R5 R9 R10 row commit visible with done");
    @(negedge clk);
    chk("R8 done one cycle", done, 0);
  endtask

  initial begin
    int guard = 0;
    while (!finished) begin
      @(posedge clk);
      guard++;
      if (guard > 150000) begin
        fails++; total++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < DEPTH; a++) mem_m[a] = 8'hFF;
    for (int b = 0; b < ROW_BYTES; b++) hold_m[b] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy reset", busy, 0);
    chk("R1 done reset", done, 0);
    chk("R1 ready reset", wr_ready, 1);
    verify_mem("R1 memory erased");

    // edge offsets and a partial row
    put_byte(0, 8'hA5);
    put_byte(ROW_BYTES - 1, 8'h3C);
    verify_mem("R2 short write leaves memory");
    run_prog(1, 1);

    // R7: empty bank after commit, the dropped write must not show up
    run_prog(1, 0);

    // R6: FFh does not set bits back
    put_byte(0, 8'hFF);
    put_byte(1, 8'h0F);
    run_prog(1, 0);

    // R4: request during busy must not program another row
    put_byte(7, 8'h11);
    run_prog(2, 1);

    for (int round = 0; round < 8; round++) begin
      int n = 1 + ($urandom % 24);
      for (int k = 0; k < n; k++)
        put_byte(int'($urandom % ROW_BYTES), 8'($urandom | $urandom));
      run_prog(int'($urandom % ROWS), round[0]);
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule